// File: doc/BRIEF.md
# Framed Multi-Queue FIFO with Packet Gating

This block is a synchronous first-in first-out store split into a set of independent queues that share one write port and one read port. Every 36-bit word holds two framing flags, two byte-validity bits and 32 bits of payload. The write side picks a queue for each word. For each queue the logic tracks whether a frame is open and counts how many complete frames the queue holds. A complete frame runs from a start-flagged word to the next end-flagged word.

The read side is gated by that frame count, not by how many words the queue holds. A word can leave a queue only when the queue already holds a whole frame, or when the frame it belongs to is already being drained. Two active-low flags report on the queue that is being read. `pkt_ready_n` is low while at least one complete frame is waiting and has not yet started to leave. `out_valid_n` stays low until the end word of the frame in flight has left. The read-queue select only takes effect between frames, so a frame is never split across queues. A repeated start flag or a repeated end flag is not treated as framing. A spare end-flagged word can therefore be used to pad a frame.

Top module: `framed_mq_fifo`

## Requirements
- R1: While `rst` is high and after it falls, `pkt_ready_n` and `out_valid_n` are 1 and `rd_valid` and `wr_overflow` are 0.
- R2: The word layout is: bit 35 is the end flag, bit 34 is the start flag, bits 33:32 are byte-validity bits, and bits 31:0 are payload. A read accepted at a clock edge presents the stored word, all 36 bits unchanged, on `rd_data`, with `rd_valid` high, just after that edge.
- R3: A read request on a queue that holds no complete frame and has none in flight, whether the queue is empty or holds only part of a frame, is refused. `rd_valid` stays 0 and no word is consumed.
- R4: When a write completes a frame in the queue selected by `rd_q`, `pkt_ready_n` is 0 just after the edge that stores the end word.
- R5: Reading the start word of the only waiting complete frame drives `pkt_ready_n` to 1. `out_valid_n` stays 0 until that frame's end word has been read, and goes to 1 after it if no other frame is waiting.
- R6: If a further frame completes while an earlier one is draining, reads run straight from the earlier frame's end word into the new frame's start word.
- R7: A start flag seen while a frame is already open does not open another frame. An end flag seen while no frame is open does not complete one. A frame padded with a second end word counts once, and the padding word cannot be read until another frame completes behind it.
- R8: Frame counts are kept separately for each of the NQ queues. The flags describe the queue chosen on `rd_q` at the previous edge, or the draining queue while a frame is in flight.
- R9: A write to a queue that already holds DEPTH words is dropped, and `wr_overflow` is 1 just after that edge. A queue accepts exactly DEPTH words.
- R10: A change of `rd_q` while a frame is in flight has no effect until that frame's end word has been read. The next read then takes words from the newly selected queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_q | input | QW | Queue that receives the write |
| wr_data | input | 36 | Word to store |
| wr_overflow | output | 1 | Previous write was dropped because the queue was full |
| rd_en | input | 1 | Read request |
| rd_q | input | QW | Queue to read from; taken up only between frames |
| rd_data | output | 36 | Word read out, valid while rd_valid is high |
| rd_valid | output | 1 | rd_data holds a word accepted at the previous edge |
| pkt_ready_n | output | 1 | Low while the observed queue holds a waiting complete frame |
| out_valid_n | output | 1 | Low while a frame is in flight or waiting on the observed queue |

## Verification
Every output is a register, so each result is due just after the edge that acts on the stimulus. The read word, `rd_valid` and both flags settle after the read edge. `pkt_ready_n` settles after the edge that stores an end word. `wr_overflow` settles after the refused write. The bench drives inputs and samples outputs one time unit after each rising edge, once that edge has updated the registers. Each check therefore sees exactly one edge's worth of change. Continuous reads hold `rd_en` high across edges and check each word and both flags after every edge in turn.

// File: rtl/fmq_pkg.sv
package fmq_pkg;
  localparam int WORD_W  = 36;
  localparam int EOP_BIT = 35;
  localparam int SOP_BIT = 34;

  typedef struct packed {
    logic eop;
    logic sop;
  } mark_t;

  function automatic mark_t get_mark(input logic [WORD_W-1:0] w);
    mark_t m;
    m.eop = w[EOP_BIT];
    m.sop = w[SOP_BIT];
    return m;
  endfunction
endpackage

// File: rtl/fmq_frame_wr.sv
module fmq_frame_wr
  import fmq_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_fire,
  input  logic [QW-1:0] wr_q,
  input  mark_t         mk,
  output logic [NQ-1:0] done
);

  for (genvar gi = 0; gi < NQ; gi++) begin : g_q
    logic in_pkt;
    logic sel;

    assign sel      = wr_fire && (wr_q == QW'(gi));
    assign done[gi] = sel && mk.eop && in_pkt;

    always_ff @(posedge clk) begin
      if (rst) begin
        in_pkt <= 1'b0;
      end else if (sel) begin
        if (!in_pkt && mk.sop)      in_pkt <= 1'b1;
        else if (in_pkt && mk.eop)  in_pkt <= 1'b0;
      end
    end

    // R7
    dup_start_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (sel && in_pkt && mk.sop && !mk.eop) |=> in_pkt);
  end

endmodule

// File: rtl/fmq_store.sv
module fmq_store
  import fmq_pkg::*;
#(
  parameter int NQ = 8,
  parameter int AW = 4,
  localparam int QW = $clog2(NQ),
  localparam int AD = QW + AW,
  localparam int NW = NQ << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AD-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AD-1:0]     raddr,
  output logic [WORD_W-1:0] rd_word,
  output mark_t             rd_mark
);

  logic [WORD_W-1:0] mem    [NW];
  mark_t             mk_mem [NW];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr]    <= wdata;
      mk_mem[waddr] <= get_mark(wdata);
    end
    if (re) rd_word <= mem[raddr];
  end

  assign rd_mark = mk_mem[raddr];

endmodule

// File: rtl/framed_mq_fifo.sv
module framed_mq_fifo
  import fmq_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int DEPTH = 16,
  localparam int QW = $clog2(NQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [QW-1:0]     wr_q,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_overflow,
  input  logic              rd_en,
  input  logic [QW-1:0]     rd_q,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              pkt_ready_n,
  output logic              out_valid_n
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [AW-1:0] wptr [NQ];
  logic [AW-1:0] rptr [NQ];
  logic [CW-1:0] occ  [NQ];
  logic [CW-1:0] pcnt [NQ];
  logic [CW-1:0] pcnt_nx [NQ];
  logic [NQ-1:0] done, taken;
  logic          drain, drain_nx;
  logic [QW-1:0] act_q, eq;
  logic          wr_fire, rd_fire, start_rd, end_rd;
  mark_t         rmk;

  fmq_frame_wr #(.NQ(NQ)) u_frame (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_q(wr_q),
    .mk(get_mark(wr_data)), .done(done)
  );

  fmq_store #(.NQ(NQ), .AW(AW)) u_store (
    .clk(clk), .we(wr_fire), .waddr({wr_q, wptr[wr_q]}), .wdata(wr_data),
    .re(rd_fire), .raddr({eq, rptr[eq]}), .rd_word(rd_data), .rd_mark(rmk)
  );

  always_comb begin
    wr_fire  = wr_en && (occ[wr_q] != CW'(DEPTH));
    eq       = drain ? act_q : rd_q;
    rd_fire  = rd_en && (drain || (pcnt[eq] != '0));
    start_rd = rd_fire && !drain && rmk.sop;
    end_rd   = rd_fire && drain && rmk.eop;
    drain_nx = start_rd ? 1'b1 : (end_rd ? 1'b0 : drain);
    for (int q = 0; q < NQ; q++) begin
      taken[q]   = start_rd && (eq == QW'(q));
      pcnt_nx[q] = pcnt[q] + CW'(done[q]) - CW'(taken[q]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < NQ; q++) begin
        wptr[q] <= '0;
        rptr[q] <= '0;
        occ[q]  <= '0;
        pcnt[q] <= '0;
      end
      drain       <= 1'b0;
      act_q       <= '0;
      rd_valid    <= 1'b0;
      wr_overflow <= 1'b0;
      pkt_ready_n <= 1'b1;
      out_valid_n <= 1'b1;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (wr_fire && (wr_q == QW'(q))) wptr[q] <= wptr[q] + 1'b1;
        if (rd_fire && (eq == QW'(q)))   rptr[q] <= rptr[q] + 1'b1;
        occ[q]  <= occ[q] + CW'(wr_fire && (wr_q == QW'(q)))
                          - CW'(rd_fire && (eq == QW'(q)));
        pcnt[q] <= pcnt_nx[q];
      end
      drain       <= drain_nx;
      act_q       <= eq;
      rd_valid    <= rd_fire;
      wr_overflow <= wr_en && !wr_fire;
      pkt_ready_n <= (pcnt_nx[eq] == '0);
      out_valid_n <= !(drain_nx || (pcnt_nx[eq] != '0));
    end
  end

  // R3
  no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    rd_fire |-> (occ[eq] != '0));

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  // R9
  overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wr_overflow |-> $past(wr_en));

  // R10
  queue_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (drain && $past(drain)) |-> (act_q == $past(act_q)));

  // R5
  ready_implies_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !pkt_ready_n |-> !out_valid_n);

endmodule

// File: tb/tb_framed_mq_fifo.sv
module tb_framed_mq_fifo;
  localparam int NQ = 8;
  localparam int DEPTH = 16;
  localparam int QW = $clog2(NQ);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [QW-1:0] wr_q = '0, rd_q = '0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic wr_overflow, rd_valid, pkt_ready_n, out_valid_n;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  framed_mq_fifo #(.NQ(NQ), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
    .wr_overflow(wr_overflow), .rd_en(rd_en), .rd_q(rd_q), .rd_data(rd_data),
    .rd_valid(rd_valid), .pkt_ready_n(pkt_ready_n), .out_valid_n(out_valid_n)
  );

  // rows: {expected out_valid_n, expected pkt_ready_n, word} after each write
  localparam logic [37:0] TBL [4] = '{
    {2'b11, 36'h4_1111_0001},
    {2'b11, 36'h1_2222_0002},
    {2'b11, 36'h2_3333_0003},
    {2'b00, 36'hB_4444_0004}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input int q, input logic [35:0] w);
    wr_en = 1'b1; wr_q = QW'(q); wr_data = w;
    tick();
    wr_en = 1'b0;
  endtask

  function automatic logic [35:0] pw(input int i, input logic [15:0] tag, input int len);
    return {(i == len - 1), (i == 0), 2'(i), tag, 16'(i)};
  endfunction

  task automatic put_pkt(input int q, input logic [15:0] tag, input int len);
    for (int i = 0; i < len; i++) put(q, pw(i, tag, len));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 prn", pkt_ready_n, 1);
    chk("R1 ovn", out_valid_n, 1);
    chk("R1 rdv", rd_valid, 0);
    chk("R1 ovf", wr_overflow, 0);
    rst = 1'b0;
    tick();
    chk("R1 prn after", pkt_ready_n, 1);
    chk("R1 ovn after", out_valid_n, 1);

    // Table walk: write a frame to queue 2, then read it back
    rd_q = 3'd2;
    for (int i = 0; i < 4; i++) begin
      put(2, TBL[i][35:0]);
      chk("R4 prn on write", pkt_ready_n, TBL[i][36]);
      chk("R4 ovn on write", out_valid_n, TBL[i][37]);
    end
    rd_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R2 rdv", rd_valid, 1);
      chk("R2 word", rd_data, TBL[i][35:0]);
      chk("R5 prn drain", pkt_ready_n, 1);
      chk("R5 ovn drain", out_valid_n, (i == 3));
    end
    tick();
    chk("R3 empty read refused", rd_valid, 0);
    rd_en = 1'b0;

    // R3 partial frame blocks reads
    rd_q = 3'd3;
    for (int i = 0; i < 3; i++) put(3, pw(i, 16'h0303, 4));
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R3 partial read refused", rd_valid, 0);
    chk("R3 partial prn", pkt_ready_n, 1);
    put(3, pw(3, 16'h0303, 4));
    chk("R4 prn complete", pkt_ready_n, 0);
    rd_en = 1'b1; tick();
    chk("R3 nothing consumed", rd_data, pw(0, 16'h0303, 4));
    repeat (3) tick();
    rd_en = 1'b0;

    // R7 duplicate start and padding end
    rd_q = 3'd4;
    put(4, 36'h4_0000_00A1);
    put(4, 36'h0_0000_00A2);
    put(4, 36'h4_0000_00A3);
    put(4, 36'h8_0000_00A4);
    chk("R7 prn one frame", pkt_ready_n, 0);
    put(4, 36'h8_0000_00A5);
    rd_en = 1'b1;
    repeat (4) tick();
    chk("R7 last word", rd_data, 36'h8_0000_00A4);
    chk("R7 prn after frame", pkt_ready_n, 1);
    chk("R7 ovn after frame", out_valid_n, 1);
    tick();
    chk("R7 padding held", rd_valid, 0);
    rd_en = 1'b0;

    // R8 independent queues
    rd_q = 3'd6;
    put_pkt(5, 16'h0505, 4);
    chk("R8 other queue not ready", pkt_ready_n, 1);
    rd_q = 3'd5; tick();
    chk("R8 own queue ready", pkt_ready_n, 0);

    // R6 second frame arrives during drain
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R6 first start", rd_data, pw(0, 16'h0505, 4));
    chk("R5 prn after start", pkt_ready_n, 1);
    chk("R5 ovn after start", out_valid_n, 0);
    put_pkt(5, 16'h5555, 4);
    chk("R6 prn new frame", pkt_ready_n, 0);
    rd_en = 1'b1;
    for (int i = 1; i < 8; i++) begin
      tick();
      chk("R6 rdv", rd_valid, 1);
      chk("R6 word", rd_data, (i < 4) ? pw(i, 16'h0505, 4) : pw(i - 4, 16'h5555, 4));
      if (i == 3) chk("R6 ovn between frames", out_valid_n, 0);
      if (i == 4) chk("R6 prn second start", pkt_ready_n, 1);
    end
    chk("R5 ovn at end", out_valid_n, 1);
    rd_en = 1'b0;

    // R10 queue switch only between frames
    put_pkt(6, 16'h0606, 4);
    put_pkt(7, 16'h0707, 4);
    rd_q = 3'd6;
    rd_en = 1'b1; tick();
    chk("R10 q6 start", rd_data, pw(0, 16'h0606, 4));
    rd_q = 3'd7;
    for (int i = 1; i < 4; i++) begin
      tick();
      chk("R10 stays on q6", rd_data, pw(i, 16'h0606, 4));
    end
    tick();
    chk("R10 moves to q7", rd_data, pw(0, 16'h0707, 4));
    repeat (3) tick();
    rd_en = 1'b0;

    // R9 full queue
    rd_q = 3'd1;
    put_pkt(1, 16'h0101, DEPTH);
    chk("R9 no overflow at depth", wr_overflow, 0);
    put(1, 36'h4_DEAD_BEEF);
    chk("R9 overflow flagged", wr_overflow, 1);
    tick();
    chk("R9 overflow pulse ends", wr_overflow, 0);
    rd_en = 1'b1;
    repeat (DEPTH) tick();
    chk("R9 last stored word", rd_data, pw(DEPTH - 1, 16'h0101, DEPTH));
    tick();
    chk("R9 dropped word absent", rd_valid, 0);
    rd_en = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule